// File: doc/BRIEF.md
# LIN-Capable Asynchronous Serial Channel

This block is a full-duplex asynchronous serial channel. Its transmitter and receiver run at the same time, both paced by a shared programmable baud divider. Each direction has a one-entry holding register in front of its shift register. Software-side logic can therefore hand over the next byte while the current one is still on the line, and it has a whole character time to collect a received byte. Characters carry eight data bits, least significant first, then an optional even or odd parity bit and one stop bit.

For use as a LIN link layer, the transmitter can send a break on request. A break is a dominant (low) stretch of 13 to 16 bit times followed by a recessive (high) delimiter of 1 to 4 bit times. The receiver recognises a long low stretch as a break and reports it on a separate flag, not as a framing error. Errors are reported per character: parity mismatch, low stop bit, and a character arriving while the previous one is still unread.

Top module: `lin_uart`

## Requirements
- R1: After reset, txd is high, tx_ready is 1, tx_busy is 0, rx_valid is 0 and err_parity, err_frame, err_overrun and brk_det are 0.
- R2: One bit time lasts 16*(cfg_div+1) clock cycles for both directions. Transmit and receive operate concurrently. Because the tick grid is free-running, the first transmitted bit after idle may be up to cfg_div cycles short.
- R3: A transmitted character is a low start bit, then tx_data bits 0 to 7 in that order, then (when cfg_par_en=1) a parity bit, then one high stop bit. The parity bit is the XOR of the eight data bits when cfg_par_odd=0 and its inverse when cfg_par_odd=1.
- R4: A write happens on a cycle with tx_valid=1 and tx_ready=1, and tx_ready stays 0 while the holding register is occupied. A second byte written while the first is shifting out starts directly after the first one's stop bit, 10 bit times (no parity) after the first start bit.
- R5: brk_req sampled while tx_busy=0 and tx_ready=1 drives txd low for exactly 13+cfg_brk_len bit times (cfg_brk_len is 2 bits), then high for 1+cfg_delim_len bit times (cfg_delim_len is 2 bits). tx_busy stays 1 from the cycle after the request until the delimiter ends.
- R6: brk_req raised while a character is being sent has no effect: no break follows the character.
- R7: Reception starts on a falling edge of rxd that is still low at mid start bit. A shorter low pulse is ignored and produces no character.
- R8: After the stop bit the received byte appears on rx_data with rx_valid=1. Both hold until a one-cycle rx_read pulse, which clears rx_valid, err_parity, err_frame, err_overrun and brk_det.
- R9: With cfg_par_en=1, a received parity bit that differs from the rule of R3 sets err_parity together with rx_valid. A matching bit leaves it 0.
- R10: A stop bit sampled low on a character that is not a break sets err_frame together with rx_valid.
- R11: A character that completes while rx_valid=1 and rx_read=0 sets err_overrun. rx_data keeps the earlier byte and the new byte is discarded.
- R12: At least 11 consecutive low bit times from a start bit set brk_det without setting rx_valid or err_frame. A zero byte with a low stop bit and no parity followed by a high 11th bit is instead delivered as data 0x00 with err_frame=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 16 | Baud divider; oversampling tick every cfg_div+1 cycles |
| cfg_par_en | input | 1 | Parity bit present when 1 |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd |
| cfg_brk_len | input | 2 | Break length select, 13+value bit times |
| cfg_delim_len | input | 2 | Delimiter length select, 1+value bit times |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Write strobe for tx_data |
| tx_ready | output | 1 | Transmit holding register empty |
| brk_req | input | 1 | Request a break field and delimiter |
| tx_busy | output | 1 | Transmitter sending a character, break or delimiter |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting to be read |
| rx_read | input | 1 | Read acknowledge; clears data-valid and all flags |
| err_parity | output | 1 | Parity mismatch on held character |
| err_frame | output | 1 | Low stop bit on held character |
| err_overrun | output | 1 | A character was lost while the holder was full |
| brk_det | output | 1 | Break seen on rxd |

## Verification
Every byte value is sent out and received at the same time with parity off, and large sets of values with even and odd parity. These sweeps separate bit-order, parity-polarity and full-duplex interference faults. All sixteen break and delimiter length pairs are timed to the cycle, which exposes off-by-one counts in either field. The receiver gets a sub-half-bit glitch, a wrong parity bit, a low stop bit on nonzero data, a 10-low near-break, 11- and 13-low breaks, and two unread characters. These patterns separate start validation, error precedence between framing and break, and the retention rule on overrun. A run at a larger divider confirms that bit time scales with the divider.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;

    localparam int OVS        = 16;            // ticks per bit
    localparam int SUB_W      = $clog2(OVS);
    localparam int MID_TICK   = OVS / 2 - 1;   // start-bit confirmation tick
    localparam int DATA_BITS  = 8;
    localparam int CNT_W      = 5;             // counts bits of a frame or break
    localparam int SEL_W      = 2;             // width of length selects
    localparam int BRK_BASE   = 13;
    localparam int DELIM_BASE = 1;
    localparam int BRK_MIN_RX = 11;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK, TX_DELIM
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_EXT
    } rx_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
    } par_cfg_t;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 perr;
        logic                 ferr;
    } rx_char_t;

    function automatic logic parity_of(input logic [DATA_BITS-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/lu_baud_gen.sv
module lu_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lu_tx.sv
module lu_tx
    import lin_uart_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  par_cfg_t             pcfg,
    input  logic [SEL_W-1:0]     brk_len,
    input  logic [SEL_W-1:0]     delim_len,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 brk_req,
    output logic                 busy,
    output logic                 txd
);
    tx_state_e            st;
    logic [SUB_W-1:0]     sub;
    logic [CNT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg, hold;
    logic                 hold_full, par_bit;
    logic                 bit_end, load_now, brk_go;
    logic [CNT_W-1:0]     brk_last, delim_last;

    assign bit_end    = tick && (sub == SUB_W'(OVS - 1));
    assign brk_last   = CNT_W'(BRK_BASE - 1) + CNT_W'(brk_len);
    assign delim_last = CNT_W'(DELIM_BASE - 1) + CNT_W'(delim_len);
    assign load_now   = hold_full && ((st == TX_IDLE) || (st == TX_STOP && bit_end));
    assign brk_go     = brk_req && (st == TX_IDLE) && !hold_full;
    assign wr_ready   = !hold_full;
    assign busy       = (st != TX_IDLE);

    always_comb begin
        case (st)
            TX_START, TX_BRK: txd = 1'b0;
            TX_DATA:          txd = shreg[0];
            TX_PAR:           txd = par_bit;
            default:          txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= TX_IDLE;
            sub       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            par_bit   <= 1'b0;
        end else begin
            if (wr_valid && !hold_full) begin
                hold      <= wr_data;
                hold_full <= 1'b1;
            end else if (load_now) begin
                hold_full <= 1'b0;
            end

            if (st != TX_IDLE && tick)
                sub <= bit_end ? '0 : sub + 1'b1;

            case (st)
                TX_IDLE: begin
                    if (load_now) begin
                        st      <= TX_START;
                        shreg   <= hold;
                        par_bit <= parity_of(hold, pcfg.par_odd);
                        sub     <= '0;
                    end else if (brk_go) begin
                        st   <= TX_BRK;
                        bitn <= '0;
                        sub  <= '0;
                    end
                end
                TX_START: if (bit_end) begin
                    st   <= TX_DATA;
                    bitn <= '0;
                end
                TX_DATA: if (bit_end) begin
                    shreg <= shreg >> 1;
                    if (bitn == CNT_W'(DATA_BITS - 1))
                        st <= pcfg.par_en ? TX_PAR : TX_STOP;
                    else
                        bitn <= bitn + 1'b1;
                end
                TX_PAR: if (bit_end) st <= TX_STOP;
                TX_STOP: if (bit_end) begin
                    if (load_now) begin
                        st      <= TX_START;
                        shreg   <= hold;
                        par_bit <= parity_of(hold, pcfg.par_odd);
                    end else begin
                        st <= TX_IDLE;
                    end
                end
                TX_BRK: if (bit_end) begin
                    if (bitn == brk_last) begin
                        st   <= TX_DELIM;
                        bitn <= '0;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end
                TX_DELIM: if (bit_end) begin
                    if (bitn == delim_last) st <= TX_IDLE;
                    else                    bitn <= bitn + 1'b1;
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lu_rx.sv
module lu_rx
    import lin_uart_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  par_cfg_t pcfg,
    input  logic     rxd,
    input  logic     rd,
    output rx_char_t held,
    output logic     valid,
    output logic     ovr,
    output logic     brk
);
    localparam bit BRK_AT_STOP_NP = (DATA_BITS + 2 >= BRK_MIN_RX);
    localparam bit BRK_AT_STOP_P  = (DATA_BITS + 3 >= BRK_MIN_RX);

    logic [2:0]           sy;
    logic                 rx_s, falling;
    rx_state_e            st;
    logic [SUB_W-1:0]     sub;
    logic [CNT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_rx, all_low;
    logic                 samp, deliver, brk_ev, brk_at_stop;
    rx_char_t             dchar;

    assign rx_s        = sy[1];
    assign falling     = sy[2] && !sy[1];
    assign samp        = tick && (sub == SUB_W'(OVS - 1));
    assign brk_at_stop = pcfg.par_en ? BRK_AT_STOP_P : BRK_AT_STOP_NP;

    always_comb begin
        deliver    = 1'b0;
        brk_ev     = 1'b0;
        dchar.data = shreg;
        dchar.perr = pcfg.par_en && (par_rx != parity_of(shreg, pcfg.par_odd));
        dchar.ferr = 1'b0;
        if (st == RX_STOP && samp) begin
            if (rx_s) begin
                deliver = 1'b1;
            end else if (!all_low) begin
                deliver    = 1'b1;
                dchar.ferr = 1'b1;
            end else if (brk_at_stop) begin
                brk_ev = 1'b1;
            end
        end
        if (st == RX_EXT && samp) begin
            if (rx_s) begin
                deliver    = 1'b1;
                dchar.ferr = 1'b1;
            end else begin
                brk_ev = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sy      <= '1;
            st      <= RX_IDLE;
            sub     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_rx  <= 1'b0;
            all_low <= 1'b0;
            held    <= '0;
            valid   <= 1'b0;
            ovr     <= 1'b0;
            brk     <= 1'b0;
        end else begin
            sy <= {sy[1:0], rxd};

            if (st != RX_IDLE && tick)
                sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + 1'b1;

            case (st)
                RX_IDLE: if (falling) begin
                    st  <= RX_START;
                    sub <= '0;
                end
                RX_START: if (tick && sub == SUB_W'(MID_TICK)) begin
                    if (!rx_s) begin
                        st      <= RX_DATA;
                        sub     <= '0;
                        bitn    <= '0;
                        all_low <= 1'b1;
                    end else begin
                        st <= RX_IDLE;
                    end
                end
                RX_DATA: if (samp) begin
                    shreg   <= {rx_s, shreg[DATA_BITS-1:1]};
                    all_low <= all_low && !rx_s;
                    if (bitn == CNT_W'(DATA_BITS - 1))
                        st <= pcfg.par_en ? RX_PAR : RX_STOP;
                    else
                        bitn <= bitn + 1'b1;
                end
                RX_PAR: if (samp) begin
                    par_rx  <= rx_s;
                    all_low <= all_low && !rx_s;
                    st      <= RX_STOP;
                end
                RX_STOP: if (samp) st <= (deliver || brk_ev) ? RX_IDLE : RX_EXT;
                RX_EXT:  if (samp) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase

            if (rd) begin
                valid     <= 1'b0;
                ovr       <= 1'b0;
                brk       <= 1'b0;
                held.perr <= 1'b0;
                held.ferr <= 1'b0;
            end
            if (deliver) begin
                if (valid && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    held  <= dchar;
                    valid <= 1'b1;
                end
            end
            if (brk_ev) brk <= 1'b1;
        end
    end
endmodule

// File: rtl/lin_uart.sv
module lin_uart
    import lin_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic [SEL_W-1:0]     cfg_brk_len,
    input  logic [SEL_W-1:0]     cfg_delim_len,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic                 brk_req,
    output logic                 tx_busy,
    output logic                 txd,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    input  logic                 rx_read,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_overrun,
    output logic                 brk_det
);
    logic     tick;
    par_cfg_t pcfg;
    rx_char_t held;

    assign pcfg.par_en  = cfg_par_en;
    assign pcfg.par_odd = cfg_par_odd;

    lu_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk (clk),
        .rst (rst),
        .div (cfg_div),
        .tick(tick)
    );

    lu_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .pcfg     (pcfg),
        .brk_len  (cfg_brk_len),
        .delim_len(cfg_delim_len),
        .wr_data  (tx_data),
        .wr_valid (tx_valid),
        .wr_ready (tx_ready),
        .brk_req  (brk_req),
        .busy     (tx_busy),
        .txd      (txd)
    );

    lu_rx u_rx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pcfg (pcfg),
        .rxd  (rxd),
        .rd   (rx_read),
        .held (held),
        .valid(rx_valid),
        .ovr  (err_overrun),
        .brk  (brk_det)
    );

    assign rx_data    = held.data;
    assign err_parity = held.perr;
    assign err_frame  = held.ferr;
endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       brk_req,
    input logic       tx_busy,
    input logic       txd,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_read,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       brk_det
);
    AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready |=> !tx_ready); // R4

    AST_LOW_LINE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !txd |-> tx_busy); // R5

    AST_BRK_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
        brk_req && tx_ready && !tx_busy |=> tx_busy && !txd); // R5

    AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_read |=> rx_valid && $stable(rx_data)); // R8

    AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $past(rx_valid)); // R11

    AST_BRK_NOT_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_det) |-> !$rose(err_frame)); // R12
endmodule

bind lin_uart lin_uart_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .brk_req    (brk_req),
    .tx_busy    (tx_busy),
    .txd        (txd),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_read    (rx_read),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .brk_det    (brk_det)
);

// File: tb/lin_uart_test.sv
`timescale 1ns/1ps
module lin_uart_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_div = 16'd0;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [1:0]  cfg_brk_len = 2'd0, cfg_delim_len = 2'd0;
    logic [7:0]  tx_data = 8'd0;
    logic        tx_valid = 1'b0, brk_req = 1'b0, rxd = 1'b1, rx_read = 1'b0;
    logic        tx_ready, tx_busy, txd, rx_valid;
    logic        err_parity, err_frame, err_overrun, brk_det;
    logic [7:0]  rx_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lin_uart uut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_brk_len(cfg_brk_len),
        .cfg_delim_len(cfg_delim_len), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .brk_req(brk_req), .tx_busy(tx_busy), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .brk_det(brk_det)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] v, input logic odd);
        return (^v) ^ odd;
    endfunction

    task automatic send_tx(input logic [7:0] v);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = v;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic tx_grab(input int bc, input logic pe, output logic [7:0] d,
                           output logic p, output logic stp, output logic so, output int sc);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        sc = cyc;
        repeat (bc / 2) @(negedge clk);
        so = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            d[i] = txd;
        end
        p = 1'b0;
        if (pe) begin
            repeat (bc) @(negedge clk);
            p = txd;
        end
        repeat (bc) @(negedge clk);
        stp = txd;
    endtask

    task automatic rx_send(input int bc, input logic [7:0] v, input logic pe,
                           input logic pb, input logic stopv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = v[i];
            repeat (bc) @(negedge clk);
        end
        if (pe) begin
            rxd = pb;
            repeat (bc) @(negedge clk);
        end
        rxd = stopv;
        repeat (bc) @(negedge clk);
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic pulse_read();
        @(negedge clk);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic wait_tx_idle();
        @(negedge clk);
        while (tx_busy) @(negedge clk);
    endtask

    task automatic run_pair(input logic [7:0] tv, input logic [7:0] rv, input int bc);
        logic [7:0] d;
        logic p, s, so;
        int sc;
        fork
            begin send_tx(tv); tx_grab(bc, cfg_par_en, d, p, s, so, sc); end
            rx_send(bc, rv, cfg_par_en, exp_par(rv, cfg_par_odd), 1'b1);
        join
        check("R3 tx frame {stop,par,data,start}", {s, p, d, so},
              {1'b1, cfg_par_en ? exp_par(tv, cfg_par_odd) : 1'b0, tv, 1'b1});
        check("R9 rx {valid,perr,ferr,data}", {rx_valid, err_parity, err_frame, rx_data},
              {1'b1, 1'b0, 1'b0, rv});
        pulse_read();
        check("R8 rx_valid cleared by read", rx_valid, 0);
        wait_tx_idle();
    endtask

    task automatic tx_break(input logic [1:0] b, input logic [1:0] dl, input int bc, input int slack);
        int lo, hi;
        cfg_brk_len   = b;
        cfg_delim_len = dl;
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        lo = 0;
        while (txd === 1'b0) begin lo++; @(negedge clk); end
        hi = 0;
        while (tx_busy === 1'b1 && txd === 1'b1) begin hi++; @(negedge clk); end
        if (slack == 0) begin
            check("R5 break low length", lo, bc * (13 + int'(b)));
            check("R5 delimiter length", hi, bc * (1 + int'(dl)));
        end else begin
            check("R2 break low scaled by divider",
                  (lo <= bc * 13) && (lo >= bc * 13 - slack), 1);
        end
        check("R5 busy falls after delimiter", tx_busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d1, d2;
        logic p1, s1, o1, p2, s2, o2;
        int c1, c2, lowc;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {txd, tx_ready, tx_busy, rx_valid, err_parity,
              err_frame, err_overrun, brk_det}, 8'b1100_0000);

        // R3 R8 sweep, no parity, full duplex at divider 0
        for (int v = 0; v < 256; v++) run_pair(8'(v), 8'(v ^ 8'hA5), 16);
        // even parity
        cfg_par_en = 1'b1;
        for (int v = 0; v < 128; v++) run_pair(8'(v * 2 + 1), 8'(v * 3), 16);
        // odd parity
        cfg_par_odd = 1'b1;
        for (int v = 0; v < 64; v++) run_pair(8'(v * 4), 8'(255 - v), 16);

        // R9 wrong parity bit (odd mode)
        rx_send(16, 8'h0F, 1'b1, ~exp_par(8'h0F, 1'b1), 1'b1);
        check("R9 parity error flagged", {rx_valid, err_parity, rx_data}, {1'b1, 1'b1, 8'h0F});
        pulse_read();
        check("R8 read clears perr", {rx_valid, err_parity}, 0);

        // R12 zero byte, low parity bit (even) and low stop: 11 lows is a break
        cfg_par_odd = 1'b0;
        rx_send(16, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R12 11-low break with parity", {brk_det, rx_valid, err_frame}, 3'b100);
        pulse_read();
        check("R8 read clears brk_det", brk_det, 0);

        cfg_par_en = 1'b0;
        // R10 low stop on nonzero data
        rx_send(16, 8'h5A, 1'b0, 1'b0, 1'b0);
        check("R10 framing error", {rx_valid, err_frame, brk_det, rx_data}, {3'b110, 8'h5A});
        pulse_read();
        check("R8 read clears ferr", {rx_valid, err_frame}, 0);

        // R12 10 lows then high: framing error on zero byte
        rx_send(16, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R12 near-break is framing error", {rx_valid, err_frame, brk_det, rx_data},
              {3'b110, 8'h00});
        pulse_read();

        // R12 13-bit break on rxd
        @(negedge clk);
        rxd = 1'b0;
        repeat (13 * 16) @(negedge clk);
        rxd = 1'b1;
        repeat (32) @(negedge clk);
        check("R12 long break detected", {brk_det, rx_valid, err_frame}, 3'b100);
        pulse_read();

        // R7 glitch shorter than half a bit
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (48) @(negedge clk);
        check("R7 glitch ignored", {rx_valid, brk_det, err_frame}, 0);
        rx_send(16, 8'h3C, 1'b0, 1'b0, 1'b1);
        check("R7 frame after glitch", {rx_valid, rx_data}, {1'b1, 8'h3C});
        pulse_read();

        // R11 overrun keeps first byte
        rx_send(16, 8'h11, 1'b0, 1'b0, 1'b1);
        rx_send(16, 8'h22, 1'b0, 1'b0, 1'b1);
        check("R11 overrun keeps data", {rx_valid, err_overrun, rx_data}, {2'b11, 8'h11});
        pulse_read();
        check("R8 read clears overrun", {rx_valid, err_overrun}, 0);

        // R4 double buffer: second write while first shifts
        fork
            begin
                send_tx(8'hC3);
                send_tx(8'h5E);
                repeat (50) @(negedge clk);
                check("R4 holding full while first shifts", tx_ready, 0);
            end
            begin
                tx_grab(16, 1'b0, d1, p1, s1, o1, c1);
                tx_grab(16, 1'b0, d2, p2, s2, o2, c2);
            end
        join
        check("R4 first byte", {s1, o1, d1}, {2'b11, 8'hC3});
        check("R4 second byte", {s2, o2, d2}, {2'b11, 8'h5E});
        check("R4 back-to-back spacing", c2 - c1, 160);
        wait_tx_idle();

        // R5 all break and delimiter lengths
        for (int b = 0; b < 4; b++)
            for (int dl = 0; dl < 4; dl++)
                tx_break(2'(b), 2'(dl), 16, 0);

        // R6 break request during a character
        cfg_brk_len = 2'd0;
        fork
            begin send_tx(8'h55); tx_grab(16, 1'b0, d1, p1, s1, o1, c1); end
            begin repeat (40) @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; end
        join
        check("R6 character unaffected", {s1, o1, d1}, {2'b11, 8'h55});
        wait_tx_idle();
        lowc = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_busy !== 1'b0) lowc++;
        end
        check("R6 no break after busy request", lowc, 0);

        // R2 larger divider: bit time 48 cycles
        cfg_div = 16'd2;
        run_pair(8'h96, 8'h69, 48);
        run_pair(8'h01, 8'h80, 48);
        tx_break(2'd0, 2'd0, 48, 2);
        cfg_div = 16'd0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule